// File: doc/BRIEF.md
# Extended Parallel Port Host Register File

This block is the processor-facing register file of an extended-capabilities parallel port. A simple synchronous bus supplies a 3-bit register select, read and write strobes and a byte of data. The register file holds the port's data latch, its control register, a read-only view of the status lines, two configuration registers and an extended control register. One 16-entry buffer sits behind three byte windows: a compatibility data FIFO, an ECP data FIFO and a test FIFO. A fourth window, the ECP address FIFO, writes into the same buffer.

The 3-bit mode field of the extended control register decides which window the buffer answers to and in which direction it moves. The cable-side handshake engine is outside this block. A plain pop port stands in for it in the forward direction and a plain push port in the reverse direction. Each buffer entry carries a command tag, so the cable side can tell an address or run-length byte from a data byte. The block reports full and empty in the extended control register and raises a service flag when the buffer crosses its threshold under programmed I/O.

Top module: `ppx_host_regs`

## Requirements
- R1: After reset, the data latch and control register read 0. The extended control register reads 8'h01: mode 000, all enables and the service flag 0, full 0 and empty 1.
- R2: The register select works the same in every mode. 0 selects the data latch (read/write). 1 selects status, read as {status lines[4:0], 3'b000}. 2 selects control, where bits 5:0 are writable, bits 7:6 read 0 and bit 5 is the direction (1 = reverse). 5 is configuration A, the constant 8'h10. 6 is configuration B, read as {2'b00, irq select[2:0], dma select[2:0]}. 7 is the extended control register.
- R3: The buffer holds 16 entries and keeps their order. In mode 010 or 011 with direction 0, a write to select 4 appends a data entry (tag 0). The cable pop port removes the oldest entry. The cable output shows the oldest entry whenever the buffer is not empty.
- R4: The extended control register is laid out as {mode[7:5], error-interrupt enable (active low) [4], dma enable [3], service [2], full [1], empty [0]}. Full and empty follow the occupancy every cycle, and writes to bits 1:0 have no effect.
- R5: A push into a full buffer is dropped and sets the overflow output. The overflow output stays set until a mode change.
- R6: A popping read of select 4 on an empty buffer returns 0 and leaves the state unchanged. Reads of select 3 always return 0 and never pop.
- R7: In mode 011 with direction 0, a write to select 3 appends the byte unchanged with tag 1. Bit 7 of that byte separates an address (1) from a run-length count (0).
- R8: Writing a mode value that differs from the current one empties the buffer. Writing the same mode value keeps the buffer contents.
- R9: The service flag is evaluated in each cycle from the current register values. It sets on the clock edge after the threshold condition goes from false to true. The condition is: mode 010, 011 or 110, dma enable 0, and either occupancy at most 8 (direction 0) or occupancy at least 8 (direction 1). Writing the extended control register with bit 2 = 0 clears the flag unless it sets in the same edge. Writing bit 2 = 1 leaves the flag unchanged.
- R10: In mode 110, writes to select 4 append entries and reads of select 4 pop them, whatever the direction. The cable pop and push ports are ignored in this mode.
- R11: In mode 011 with direction 1, the cable push port appends data entries, and reads of select 4 pop them. Host writes to select 3 and 4 are ignored in this case.
- R12: In modes 000, 001 and 111, writes to select 3 and 4 and the cable pop and push ports leave the buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 3 | Register select |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_rd | input | 1 | Read strobe for this cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle bus_rd is high, otherwise 0 |
| stat_i | input | 5 | Cable status lines shown in status bits 7:3 |
| cfg_irq_i | input | 3 | Interrupt channel shown in configuration B |
| cfg_dma_i | input | 3 | DMA channel shown in configuration B |
| pdata_o | output | 8 | Data latch contents |
| ctrl_o | output | 6 | Control register bits 5:0 |
| cab_pop_i | input | 1 | Cable side takes the oldest entry |
| cab_valid_o | output | 1 | Buffer not empty |
| cab_data_o | output | 8 | Byte of the oldest entry |
| cab_cmd_o | output | 1 | Tag of the oldest entry (1 = address/count) |
| cab_push_i | input | 1 | Cable side appends a byte |
| cab_wdata_i | input | 8 | Byte appended by the cable side |
| ovf_o | output | 1 | Sticky overflow flag |
| svc_o | output | 1 | Service flag (extended control bit 2) |

## Verification
Each mode gets its own traffic pattern. Short forward bursts popped by the cable show that order is kept. A fill of 16 followed by a seventeenth write shows the full boundary and the overflow behaviour. Mixed address and data writes show that the tag follows each entry, and reverse pushes drained by host reads show the other direction. Test-mode loopback, with cable strobes held active, shows that the cable ports are gated off. Rewriting the same mode and then a different mode separates a flush from a no-op. The fill level moves back and forth across the threshold with dma enable both off and on, which shows that the service flag sets only on the rising condition and clears only on a write of 0.

// File: rtl/ppx_pkg.sv
package ppx_pkg;

    localparam int BYTE_W = 8;
    localparam logic [7:0] CFG_A_VALUE = 8'h10;

    typedef enum logic [2:0] {
        MODE_STD   = 3'b000,
        MODE_BIDIR = 3'b001,
        MODE_CFIFO = 3'b010,
        MODE_ECP   = 3'b011,
        MODE_RSV4  = 3'b100,
        MODE_RSV5  = 3'b101,
        MODE_TEST  = 3'b110,
        MODE_CFG   = 3'b111
    } port_mode_e;

    typedef enum logic [2:0] {
        SEL_DATA  = 3'd0,
        SEL_STAT  = 3'd1,
        SEL_CTRL  = 3'd2,
        SEL_AFIFO = 3'd3,
        SEL_DFIFO = 3'd4,
        SEL_CFGA  = 3'd5,
        SEL_CFGB  = 3'd6,
        SEL_ECR   = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic              is_cmd;
        logic [BYTE_W-1:0] val;
    } fifo_entry_t;

    typedef struct packed {
        port_mode_e mode;
        logic       err_ie_n;
        logic       dma_en;
        logic       svc;
        logic       full;
        logic       empty;
    } ecr_t;

    function automatic logic buf_mode(input port_mode_e m);
        return (m == MODE_CFIFO) || (m == MODE_ECP) || (m == MODE_TEST);
    endfunction

    function automatic logic cable_drain_mode(input port_mode_e m);
        return (m == MODE_CFIFO) || (m == MODE_ECP);
    endfunction

endpackage

// File: rtl/ppx_fifo.sv
module ppx_fifo
    import ppx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        flush,
    input  logic        push,
    input  fifo_entry_t push_entry,
    input  logic        pop,
    output fifo_entry_t head,
    output logic [CW-1:0] cnt,
    output logic        full,
    output logic        empty,
    output logic        ovf
);

    fifo_entry_t   mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic          push_ok, pop_ok;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign push_ok = push && !full && !flush;
    assign pop_ok  = pop && !empty && !flush;
    assign head    = mem[rptr];

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= push_entry;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (push_ok) wptr <= nxt(wptr);
            if (pop_ok)  rptr <= nxt(rptr);
            case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) ovf <= 1'b0;
        else if (push && full) ovf <= 1'b1;
    end

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));
    p_drop_flags_r5: assert property (@(posedge clk) disable iff (rst)
        (push && full && !flush) |=> ovf);
    p_flush_empties_r8: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty);
    p_count_up_r3: assert property (@(posedge clk) disable iff (rst)
        (push && !full && !pop && !flush) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/ppx_ecr.sv
module ppx_ecr
    import ppx_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int THRESH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [7:0]    wdata,
    input  logic          dir_rev,
    input  logic [CW-1:0] cnt,
    input  logic          full,
    input  logic          empty,
    output port_mode_e    mode,
    output logic          svc,
    output logic          flush,
    output ecr_t          value
);

    logic       err_ie_n, dma_en, cond, cond_q;
    port_mode_e new_mode;

    assign new_mode = port_mode_e'(wdata[7:5]);
    assign flush    = wr && (new_mode != mode);
    assign cond     = buf_mode(mode) && !dma_en &&
                      (dir_rev ? (cnt >= CW'(THRESH)) : (cnt <= CW'(DEPTH - THRESH)));

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= MODE_STD;
            err_ie_n <= 1'b0;
            dma_en   <= 1'b0;
            svc      <= 1'b0;
            cond_q   <= 1'b0;
        end else begin
            cond_q <= cond;
            if (wr) begin
                mode     <= new_mode;
                err_ie_n <= wdata[4];
                dma_en   <= wdata[3];
            end
            if (cond && !cond_q)   svc <= 1'b1;
            else if (wr && !wdata[2]) svc <= 1'b0;
        end
    end

    always_comb begin
        value.mode     = mode;
        value.err_ie_n = err_ie_n;
        value.dma_en   = dma_en;
        value.svc      = svc;
        value.full     = full;
        value.empty    = empty;
    end

    p_svc_pio_only_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(svc) |-> !$past(dma_en));
    p_full_empty_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(value.full && value.empty));

endmodule

// File: rtl/ppx_host_regs.sv
module ppx_host_regs
    import ppx_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int THRESH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic [4:0] stat_i,
    input  logic [2:0] cfg_irq_i,
    input  logic [2:0] cfg_dma_i,
    output logic [7:0] pdata_o,
    output logic [5:0] ctrl_o,
    input  logic       cab_pop_i,
    output logic       cab_valid_o,
    output logic [7:0] cab_data_o,
    output logic       cab_cmd_o,
    input  logic       cab_push_i,
    input  logic [7:0] cab_wdata_i,
    output logic       ovf_o,
    output logic       svc_o
);

    reg_sel_e    sel;
    port_mode_e  mode;
    ecr_t        ecr_val;
    fifo_entry_t head, push_entry;
    logic [CW-1:0] cnt;
    logic [7:0]  data_q;
    logic [5:0]  ctrl_q;
    logic        dir_rev, full, empty, flush;
    logic        host_wr_data, host_wr_addr, host_pop, cab_pop, cab_push;
    logic        push, pop, ecr_wr;

    assign sel     = reg_sel_e'(bus_addr);
    assign dir_rev = ctrl_q[5];
    assign ecr_wr  = bus_wr && (sel == SEL_ECR);

    // Window gating by mode and direction
    assign host_wr_data = bus_wr && (sel == SEL_DFIFO) && buf_mode(mode) &&
                          ((mode == MODE_TEST) || !dir_rev);
    assign host_wr_addr = bus_wr && (sel == SEL_AFIFO) && (mode == MODE_ECP) && !dir_rev;
    assign host_pop     = bus_rd && (sel == SEL_DFIFO) &&
                          ((mode == MODE_TEST) || ((mode == MODE_ECP) && dir_rev));
    assign cab_pop      = cab_pop_i && !dir_rev && cable_drain_mode(mode);
    assign cab_push     = cab_push_i && dir_rev && (mode == MODE_ECP);

    assign push = host_wr_data || host_wr_addr || cab_push;
    assign pop  = host_pop || cab_pop;

    always_comb begin
        if (cab_push) begin
            push_entry.is_cmd = 1'b0;
            push_entry.val    = cab_wdata_i;
        end else begin
            push_entry.is_cmd = host_wr_addr;
            push_entry.val    = bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            ctrl_q <= '0;
        end else if (bus_wr) begin
            if (sel == SEL_DATA) data_q <= bus_wdata;
            if (sel == SEL_CTRL) ctrl_q <= bus_wdata[5:0];
        end
    end

    ppx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .push       (push),
        .push_entry (push_entry),
        .pop        (pop),
        .head       (head),
        .cnt        (cnt),
        .full       (full),
        .empty      (empty),
        .ovf        (ovf_o)
    );

    ppx_ecr #(.DEPTH(DEPTH), .THRESH(THRESH)) u_ecr (
        .clk     (clk),
        .rst     (rst),
        .wr      (ecr_wr),
        .wdata   (bus_wdata),
        .dir_rev (dir_rev),
        .cnt     (cnt),
        .full    (full),
        .empty   (empty),
        .mode    (mode),
        .svc     (svc_o),
        .flush   (flush),
        .value   (ecr_val)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (sel)
                SEL_DATA:  bus_rdata = data_q;
                SEL_STAT:  bus_rdata = {stat_i, 3'b000};
                SEL_CTRL:  bus_rdata = {2'b00, ctrl_q};
                SEL_AFIFO: bus_rdata = '0;
                SEL_DFIFO: bus_rdata = (host_pop && !empty) ? head.val : '0;
                SEL_CFGA:  bus_rdata = CFG_A_VALUE;
                SEL_CFGB:  bus_rdata = {2'b00, cfg_irq_i, cfg_dma_i};
                SEL_ECR:   bus_rdata = ecr_val;
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign pdata_o     = data_q;
    assign ctrl_o      = ctrl_q;
    assign cab_valid_o = !empty;
    assign cab_data_o  = head.val;
    assign cab_cmd_o   = head.is_cmd;

    p_empty_read_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (sel == SEL_DFIFO) && !cab_valid_o) |-> (bus_rdata == 8'h00));
    p_status_low_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (sel == SEL_STAT)) |-> (bus_rdata[2:0] == 3'b000));
    p_idle_mode_frozen_r12: assert property (@(posedge clk) disable iff (rst)
        (!buf_mode(mode) && !ecr_wr) |=> $stable(cab_valid_o));

endmodule

// File: tb/test_ppx_host_regs.sv
`timescale 1ns/1ps
module test_ppx_host_regs;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] bus_addr;
    logic       bus_wr, bus_rd;
    logic [7:0] bus_wdata, bus_rdata;
    logic [4:0] stat_i;
    logic [2:0] cfg_irq_i, cfg_dma_i;
    logic [7:0] pdata_o;
    logic [5:0] ctrl_o;
    logic       cab_pop_i, cab_valid_o, cab_cmd_o, cab_push_i, ovf_o, svc_o;
    logic [7:0] cab_data_o, cab_wdata_i;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural reference state
    int q[$];
    int m_mode, m_nerr, m_dma, m_svc, m_condq, m_ovf;
    int m_data, m_ctrl;

    always #2.5 clk = ~clk;

    ppx_host_regs i_ppx_host_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .stat_i(stat_i),
        .cfg_irq_i(cfg_irq_i), .cfg_dma_i(cfg_dma_i), .pdata_o(pdata_o), .ctrl_o(ctrl_o),
        .cab_pop_i(cab_pop_i), .cab_valid_o(cab_valid_o), .cab_data_o(cab_data_o),
        .cab_cmd_o(cab_cmd_o), .cab_push_i(cab_push_i), .cab_wdata_i(cab_wdata_i),
        .ovf_o(ovf_o), .svc_o(svc_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit is_buf(input int m);
        return (m == 2) || (m == 3) || (m == 6);
    endfunction

    function automatic int ecr_word();
        return (m_mode << 5) | (m_nerr << 4) | (m_dma << 3) | (m_svc << 2) |
               ((q.size() == 16) ? 2 : 0) | ((q.size() == 0) ? 1 : 0);
    endfunction

    task automatic model_reset();
        q.delete();
        m_mode = 0; m_nerr = 0; m_dma = 0; m_svc = 0; m_condq = 0; m_ovf = 0;
        m_data = 0; m_ctrl = 0;
    endtask

    task automatic check_state(input string tag);
        check({tag, " cab_valid"}, cab_valid_o, q.size() > 0);
        if (q.size() > 0) begin
            check({tag, " cab_data"}, cab_data_o, q[0] & 8'hFF);
            check({tag, " cab_cmd"}, cab_cmd_o, q[0] >> 8);
        end
        check("R5 ovf", ovf_o, m_ovf);
        check("R9 svc", svc_o, m_svc);
        check("R2 pdata", pdata_o, m_data);
        check("R2 ctrl", ctrl_o, m_ctrl);
    endtask

    // one bus cycle; read data checked before the edge, state after it
    task automatic step(input int a, input bit w, input bit r, input int wd,
                        input bit cp, input bit cu, input int cd, input string tag);
        int  dir, exp_rd, cond, sz;
        bit  hp, hwd, hwa, cpop, cpush, push, pop, flush;
        bus_addr = 3'(a); bus_wr = w; bus_rd = r; bus_wdata = 8'(wd);
        cab_pop_i = cp; cab_push_i = cu; cab_wdata_i = 8'(cd);
        dir = (m_ctrl >> 5) & 1;
        sz  = q.size();
        hp    = r && a == 4 && (m_mode == 6 || (m_mode == 3 && dir == 1));
        hwd   = w && a == 4 && is_buf(m_mode) && (m_mode == 6 || dir == 0);
        hwa   = w && a == 3 && m_mode == 3 && dir == 0;
        cpop  = cp && dir == 0 && (m_mode == 2 || m_mode == 3);
        cpush = cu && dir == 1 && m_mode == 3;
        #1;
        if (r) begin
            case (a)
                0: exp_rd = m_data;
                1: exp_rd = {stat_i, 3'b000};
                2: exp_rd = m_ctrl;
                4: exp_rd = (hp && sz > 0) ? (q[0] & 8'hFF) : 0;
                5: exp_rd = 8'h10;
                6: exp_rd = {2'b00, cfg_irq_i, cfg_dma_i};
                7: exp_rd = ecr_word();
                default: exp_rd = 0;
            endcase
            check({tag, " rdata"}, bus_rdata, exp_rd);
        end
        cond  = is_buf(m_mode) && m_dma == 0 && (dir ? (sz >= 8) : (sz <= 8));
        flush = w && a == 7 && ((wd >> 5) & 7) != m_mode;
        push  = hwd || hwa || cpush;
        pop   = hp || cpop;
        if (cond && !m_condq) m_svc = 1;
        else if (w && a == 7 && ((wd >> 2) & 1) == 0) m_svc = 0;
        m_condq = cond;
        if (flush) begin
            q.delete();
            m_ovf = 0;
        end else begin
            if (pop && sz > 0) void'(q.pop_front());
            if (push && sz < 16) q.push_back(cpush ? (cd & 8'hFF) : ((hwa ? 256 : 0) | (wd & 8'hFF)));
            if (push && sz == 16) m_ovf = 1;
        end
        if (w && a == 7) begin
            m_mode = (wd >> 5) & 7; m_nerr = (wd >> 4) & 1; m_dma = (wd >> 3) & 1;
        end
        if (w && a == 0) m_data = wd & 8'hFF;
        if (w && a == 2) m_ctrl = wd & 8'h3F;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; cab_pop_i = 0; cab_push_i = 0;
        check_state(tag);
    endtask

    task automatic wr(input int a, input int d, input string tag);
        step(a, 1, 0, d, 0, 0, 0, tag);
    endtask
    task automatic rd(input int a, input string tag);
        step(a, 0, 1, 0, 0, 0, 0, tag);
    endtask
    task automatic cpop(input string tag);
        step(0, 0, 0, 0, 1, 0, 0, tag);
    endtask
    task automatic cpush(input int d, input string tag);
        step(0, 0, 0, 0, 0, 1, d, tag);
    endtask

    initial begin
        #200000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1; bus_addr = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0;
        cab_pop_i = 0; cab_push_i = 0; cab_wdata_i = 0;
        stat_i = 5'b10110; cfg_irq_i = 3'd5; cfg_dma_i = 3'd2;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        check_state("R1 reset");
        rd(7, "R1 ecr"); rd(2, "R1 ctrl"); rd(0, "R1 data");

        // R2 register map
        wr(0, 8'hA5, "R2"); rd(0, "R2 data");
        wr(2, 8'hDF, "R2"); rd(2, "R2 ctrl");
        wr(2, 8'h00, "R2");
        rd(1, "R2 status"); rd(5, "R2 cfgA"); rd(6, "R2 cfgB");

        // R12 idle mode ignores windows and cable strobes
        wr(4, 8'h11, "R12"); wr(3, 8'h12, "R12"); cpop("R12"); rd(7, "R12 ecr");

        // R3 forward order in compatibility FIFO mode
        wr(7, 8'h40, "R3");
        for (int i = 0; i < 5; i++) wr(4, 8'h20 + i, "R3");
        for (int i = 0; i < 5; i++) cpop("R3");
        rd(7, "R9 ecr");
        wr(7, 8'h40, "R9 clear");
        rd(7, "R9 ecr cleared");

        // R5/R4 fill to full, overflow, full bit ignores writes
        for (int i = 0; i < 16; i++) wr(4, 8'h80 + i, "R5 fill");
        rd(7, "R4 full");
        wr(4, 8'hEE, "R5 drop");
        wr(7, 8'h47, "R4 keep mode");
        rd(7, "R4 full bits");
        wr(7, 8'h40, "R8 same mode");
        rd(7, "R8 kept");
        cpop("R9 drain");
        for (int i = 0; i < 8; i++) cpop("R9 drain");
        rd(7, "R9 threshold");

        // R8 mode change flushes and clears overflow
        wr(7, 8'h60, "R8 flush");
        rd(7, "R8 empty");

        // R7 tagged address entries in ECP forward
        wr(3, 8'h85, "R7 addr"); wr(4, 8'h33, "R7 data"); wr(3, 8'h07, "R7 count");
        rd(3, "R6 addr window");
        cpop("R7"); cpop("R7"); cpop("R7");

        // R11 reverse: cable pushes, host pops; host writes ignored
        wr(2, 8'h20, "R11 dir");
        cpush(8'h5A, "R11"); cpush(8'hC3, "R11"); wr(4, 8'h99, "R11 ignored");
        rd(4, "R11 pop"); rd(4, "R11 pop"); rd(4, "R6 empty read");
        rd(7, "R6 ecr");

        // R10 test mode loopback, cable ports ignored
        wr(7, 8'hC0, "R10");
        wr(4, 8'h01, "R10"); wr(4, 8'h02, "R10"); cpush(8'h77, "R10 ignored");
        wr(2, 8'h00, "R10 dir"); wr(4, 8'h03, "R10"); cpop("R10 ignored");
        rd(4, "R10 pop"); rd(4, "R10 pop"); rd(4, "R10 pop"); rd(4, "R6 empty");

        // R9 with dma enabled: no set
        wr(7, 8'h48, "R9 dma"); wr(7, 8'h48, "R9 dma");
        for (int i = 0; i < 10; i++) wr(4, i, "R9 dma");
        for (int i = 0; i < 10; i++) cpop("R9 dma");
        rd(7, "R9 dma ecr");
        check("R9 dma no set", svc_o, 0);

        // R9 back to PIO: rises again when crossing down to threshold
        wr(7, 8'h44, "R9 pio");
        for (int i = 0; i < 10; i++) wr(4, i, "R9 pio");
        wr(7, 8'h40, "R9 clr");
        for (int i = 0; i < 3; i++) cpop("R9 pio");
        rd(7, "R9 pio ecr");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule